// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned operands and a carry-in through a two-tier carry lookahead tree. Each bit first forms a propagate flag (the XOR of its operand bits) and a generate flag (their AND). The word is cut into equal groups. A first-tier lookahead unit per group turns the bit flags into the carries inside that group, and a separate reduction turns them into one group-propagate and one group-generate bit. A single second-tier lookahead unit takes the group flags and the adder carry-in and supplies the carry into every group. A final gate forms the carry-out from the top-level group generate, the top-level group propagate and the carry-in. Every carry is a flat sum of products of flags, so no carry ripples from one group into the next.

The group width and the group count are separate parameters, so a 64-bit adder can be split 16×4 or 8×8. Their product must equal the operand width; any other set stops elaboration with an error. The adder core has no state. The sum and carry-out are captured in output registers with a synchronous active-high reset, so a result appears one clock after its operands.

Top module: `hla_adder`

## Requirements
- R1: One clock after operands `opa`, `opb` and `carry_in` are sampled with `rst` low, `sum` equals the low WIDTH bits of opa + opb + carry_in.
- R2: In the same cycle, `carry_out` equals bit WIDTH of the WIDTH+1-bit value opa + opb + carry_in.
- R3: A clock edge with `rst` high sets `sum` to zero and `carry_out` to 0 on that edge, whatever the operands are.
- R4: When `opb` is the bitwise complement of `opa` and `carry_in` is 1, the carry crosses every bit and every group boundary: `sum` is all zeros and `carry_out` is 1.
- R5: When `opa` AND `opb` is zero in every bit and `carry_in` is 0, no carry arises: `sum` equals opa OR opb and `carry_out` is 0.
- R6: The result depends only on the operands and not on how the width is split. A 64-bit adder built 16 wide × 4 groups and one built 8 wide × 8 groups give the same `sum` and `carry_out` for the same inputs.
- R7: When both operands are all ones, `carry_out` is 1, sum bits WIDTH-1 down to 1 are all 1, and sum bit 0 equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum, low WIDTH bits |
| carry_out | output | 1 | Registered carry out of the top bit |

## Verification
The properties assume operands that are known 0/1 values on every clock edge after reset. They compare each registered output only with the inputs sampled one edge before, and only once a reset has been seen and released, so values from before the first reset are never judged. The bench follows the same rules. It drives all inputs on the falling edge, holds them across exactly one rising edge, and sends operands only after the first reset. It then sweeps every input combination of a 6-bit adder split 3×2, and applies corner and random operands to two 64-bit splits.

// File: rtl/hla_pkg.sv
package hla_pkg;

  // AND of bits lo..hi-1 of v; returns 1 for an empty range
  function automatic logic span_and(input logic [63:0] v, input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int k = 0; k < 64; k++) begin
      if (k >= lo && k < hi) r = r & v[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/hla_group_pg.sv
module hla_group_pg #(
  parameter int RADIX = 4
) (
  input  logic [RADIX-1:0] p,
  input  logic [RADIX-1:0] g,
  output logic             grp_p,
  output logic             grp_g
);
  import hla_pkg::*;

  logic [63:0] p_ext;
  assign p_ext = 64'(p);

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < RADIX; j++) begin
      acc = acc | (g[j] & span_and(p_ext, j + 1, RADIX));
    end
    grp_g = acc;
    grp_p = &p;
  end
endmodule

// File: rtl/hla_carry.sv
module hla_carry #(
  parameter int RADIX = 4
) (
  input  logic [RADIX-1:0] p,
  input  logic [RADIX-1:0] g,
  input  logic             cin,
  output logic [RADIX-1:0] c
);
  import hla_pkg::*;

  logic [63:0] p_ext;
  assign p_ext = 64'(p);

  // Each carry is a flat OR of products: carry-in term plus one term per lower generate
  always_comb begin
    logic acc;
    for (int i = 0; i < RADIX; i++) begin
      acc = cin & span_and(p_ext, 0, i);
      for (int j = 0; j < RADIX; j++) begin
        if (j < i) acc = acc | (g[j] & span_and(p_ext, j + 1, i));
      end
      c[i] = acc;
    end
  end
endmodule

// File: rtl/hla_adder.sv
module hla_adder #(
  parameter int WIDTH    = 64,
  parameter int RADIX_L1 = 16,
  parameter int RADIX_L2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int NGRP = RADIX_L2;

  if (RADIX_L1 * RADIX_L2 != WIDTH) begin : g_bad_split
    $error("hla_adder: RADIX_L1 * RADIX_L2 must equal WIDTH");
  end
  if (RADIX_L1 > 64 || RADIX_L2 > 64) begin : g_bad_radix
    $error("hla_adder: a radix may not exceed 64");
  end

  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_c;
  logic [NGRP-1:0]  grp_p;
  logic [NGRP-1:0]  grp_g;
  logic [NGRP-1:0]  grp_cin;
  logic             top_p;
  logic             top_g;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  // partial full adders: per-bit propagate and generate
  assign bit_p = opa ^ opb;
  assign bit_g = opa & opb;

  // first tier: group flags and in-group carries
  for (genvar k = 0; k < NGRP; k++) begin : g_l1
    hla_group_pg #(.RADIX(RADIX_L1)) u_pg (
      .p     (bit_p[k*RADIX_L1 +: RADIX_L1]),
      .g     (bit_g[k*RADIX_L1 +: RADIX_L1]),
      .grp_p (grp_p[k]),
      .grp_g (grp_g[k])
    );
    hla_carry #(.RADIX(RADIX_L1)) u_cy (
      .p   (bit_p[k*RADIX_L1 +: RADIX_L1]),
      .g   (bit_g[k*RADIX_L1 +: RADIX_L1]),
      .cin (grp_cin[k]),
      .c   (bit_c[k*RADIX_L1 +: RADIX_L1])
    );
  end

  // second tier: carry into each group
  hla_carry #(.RADIX(RADIX_L2)) u_l2_cy (
    .p   (grp_p),
    .g   (grp_g),
    .cin (carry_in),
    .c   (grp_cin)
  );
  hla_group_pg #(.RADIX(RADIX_L2)) u_l2_pg (
    .p     (grp_p),
    .g     (grp_g),
    .grp_p (top_p),
    .grp_g (top_g)
  );

  assign sum_c  = bit_p ^ bit_c;
  assign cout_c = top_g | (top_p & carry_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum       <= '0;
      carry_out <= 1'b0;
    end else begin
      sum       <= sum_c;
      carry_out <= cout_c;
    end
  end
endmodule

// File: rtl/hla_adder_chk.sv
module hla_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out
);
  logic seen_rst;
  logic run_q;
  logic rst_q;
  logic [WIDTH:0] ref_full;

  assign ref_full = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};

  always_ff @(posedge clk) begin
    seen_rst <= (seen_rst === 1'b1) | rst;
    run_q    <= (seen_rst === 1'b1) & !rst;
    rst_q    <= rst;
  end

  p_sum_r1: assert property (@(posedge clk) disable iff (rst)
    run_q |-> sum == $past(ref_full[WIDTH-1:0]));

  p_cout_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> carry_out == $past(ref_full[WIDTH]));

  p_reset_clear_r3: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (sum == '0 && !carry_out));

  p_full_chain_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(opa == ~opb) && $past(carry_in)) |-> (sum == '0 && carry_out));

  p_no_generate_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past((opa & opb) == '0) && !$past(carry_in)) |-> (sum == $past(opa | opb) && !carry_out));

  p_all_generate_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(&opa) && $past(&opb)) |-> (carry_out && sum == {{(WIDTH-1){1'b1}}, $past(carry_in)}));
endmodule

bind hla_adder hla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opa       (opa),
  .opb       (opb),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out)
);

// File: tb/hla_adder_bench.sv
module hla_adder_bench;
  localparam int W  = 64;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0]  a, b;
  logic          ci;
  logic [W-1:0]  s16, s8;
  logic          co16, co8;
  logic [WS-1:0] as, bs;
  logic          cis;
  logic [WS-1:0] ss;
  logic          cos;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  hla_adder #(.WIDTH(W), .RADIX_L1(16), .RADIX_L2(4)) u_hla_adder (
    .clk(clk), .rst(rst), .opa(a), .opb(b), .carry_in(ci), .sum(s16), .carry_out(co16));
  hla_adder #(.WIDTH(W), .RADIX_L1(8), .RADIX_L2(8)) u_hla_adder_8x8 (
    .clk(clk), .rst(rst), .opa(a), .opb(b), .carry_in(ci), .sum(s8), .carry_out(co8));
  hla_adder #(.WIDTH(WS), .RADIX_L1(3), .RADIX_L2(2)) u_hla_adder_small (
    .clk(clk), .rst(rst), .opa(as), .opb(bs), .carry_in(cis), .sum(ss), .carry_out(cos));

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply wide operands for one rising edge, check both splits at the next falling edge
  task automatic run_wide(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] e;
    a = x; b = y; ci = c;
    e = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    @(posedge clk);
    @(negedge clk);
    check({req, " 16x4 (R1/R2)"}, {co16, s16}, e);
    check({req, " 8x8 (R1/R2)"}, {co8, s8}, e);
    check("R6 split independence", {co8, s8}, {co16, s16});
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0; as = '0; bs = '0; cis = 1'b0;
    // reset with non-zero operands: outputs must stay cleared (R3)
    @(negedge clk);
    a = '1; b = '1; ci = 1'b1; as = '1; bs = '1; cis = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 reset clears wide", {co16, s16}, '0);
    check("R3 reset clears small", {59'd0, cos, ss}, '0);
    rst = 1'b0;

    // corners
    run_wide("R4 complement+cin", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    run_wide("R4 all ones+0+cin", '1, '0, 1'b1);
    run_wide("R5 alternating no cin", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
    run_wide("R5 zero", '0, '0, 1'b0);
    run_wide("R7 all ones cin0", '1, '1, 1'b0);
    run_wide("R7 all ones cin1", '1, '1, 1'b1);
    run_wide("R1 lsb carry chain", 64'd1, '1, 1'b0);
    run_wide("R2 group edge", 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 1'b0);

    // explicit corner expectations (R4, R5, R7)
    a = '1; b = '0; ci = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 sum zero carry one", {co16, s16}, {1'b1, {W{1'b0}}});
    a = 64'h0F0F_0F0F_0F0F_0F0F; b = 64'hF0F0_F0F0_F0F0_F0F0; ci = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 sum is OR", {co16, s16}, {1'b0, {W{1'b1}}});
    a = '1; b = '1; ci = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 all generate", {co8, s8}, {1'b1, {(W-1){1'b1}}, 1'b0});

    // mid-run reset pulse clears a non-zero result (R3)
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 mid-run reset", {co16, s16}, '0);
    rst = 1'b0;

    // random wide vectors
    for (int n = 0; n < 1500; n++) begin
      run_wide("R1 random", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end

    // exhaustive sweep of the 3x2 split
    for (int x = 0; x < (1 << WS); x++) begin
      for (int y = 0; y < (1 << WS); y++) begin
        for (int c = 0; c < 2; c++) begin
          as = WS'(x); bs = WS'(y); cis = 1'(c);
          @(posedge clk);
          @(negedge clk);
          check("R1/R2 small exhaustive", {59'd0, cos, ss}, 65'(x + y + c));
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule